// File: doc/BRIEF.md
# Streaming Decimal Number Recognizer

This block reads a stream of 8-bit ASCII characters, one per clock while `in_valid` is high. It decides whether the stream spells a signed decimal number, closed by a terminator character. A number has an optional leading minus sign and a mantissa made of integer digits, a fractional part introduced by a dot, or both. An exponent may follow, introduced by a lowercase `e`, with an optional minus sign and one or more digits.

The machine reports its progress on a 3-bit state port. Once a whole number has been seen, `num_ok` rises. As soon as the stream can no longer form a number, `num_err` rises. Both verdicts hold until a synchronous reset returns the machine to its start state.

Each character is first reduced to a small class code. The next state is then computed from the registered context and that class. A parameter selects how this is done: by plain logic, or by a 256-entry lookup table that is filled from the same transition function.

Top module: `numlex_top`

## Requirements
- R1: When `rst` is high at a rising clock edge, the machine returns after that edge to state 000 (start), with `num_ok` and `num_err` both low.
- R2: A clock edge with `in_valid` low changes neither `state_o`, `num_ok` nor `num_err`, whatever `in_char` holds.
- R3: `state_o` shows the state one cycle after each accepted character, with these codes: start 000, sign 001, whole 010, frac 011, exp 100, done 101, error 110. Code 111 never appears.
- R4: The mantissa is an optional '-' (0x2D), then digits '0'..'9' (0x30..0x39), then an optional '.' (0x2E) with further digits. It must contain at least one digit, placed before or after the dot.
- R5: The exponent is 'e' (0x65), allowed only after a mantissa that has a digit. A single '-' may come only as the first character after 'e', and at least one digit must follow. Uppercase 'E' (0x45) is not accepted.
- R6: A terminator ends a well-formed number and moves the machine to done (101), and `num_ok` is then high. The terminators are space 0x20, tab 0x09, CR 0x0D, LF 0x0A and NUL 0x00.
- R7: A character that has no transition from the current state moves the machine to error (110), and `num_err` is then high. This includes a leading terminator, a second dot and letters.
- R8: A terminator that comes after a lone '-', a lone '.', an 'e' with no exponent digits, or "e-" with no digits moves the machine to error.
- R9: The done and error states are terminal. No character leaves them. Only reset does.
- R10: `num_ok` is high exactly in done and `num_err` exactly in error, so the two are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset to the start state |
| in_valid | input | 1 | Qualifies `in_char` in this cycle |
| in_char | input | 8 | ASCII character to consume |
| state_o | output | 3 | Registered recognizer state code |
| num_ok | output | 1 | Registered: a complete number was recognized |
| num_err | output | 1 | Registered: the stream cannot form a number |

## Verification
The assertions assume that `rst` is held for at least one rising edge before the first check. They also assume that `in_char` is a defined 8-bit value whenever `in_valid` is high. The bench keeps to both assumptions: it drives every input only on falling edges, holds reset across an edge between scenarios, and always places a concrete byte on `in_char`, including while `in_valid` is low. Every scenario begins from a fresh reset, so the claim that only a terminator can raise `num_ok` is never tested against a verdict left over from an earlier string.

// File: rtl/numlex_pkg.sv
`timescale 1ns/1ps
package numlex_pkg;

  localparam int ST_W   = 3;
  localparam int AUX_W  = 2;
  localparam int CLS_W  = 3;
  localparam int CTX_W  = ST_W + AUX_W;
  localparam int IDX_W  = CTX_W + CLS_W;

  typedef enum logic [ST_W-1:0] {
    ST_START = 3'b000,
    ST_SIGN  = 3'b001,
    ST_WHOLE = 3'b010,
    ST_FRAC  = 3'b011,
    ST_EXP   = 3'b100,
    ST_DONE  = 3'b101,
    ST_ERROR = 3'b110
  } nl_state_e;

  typedef enum logic [CLS_W-1:0] {
    CC_DIGIT  = 3'd0,
    CC_MINUS  = 3'd1,
    CC_DOT    = 3'd2,
    CC_EXPMRK = 3'd3,
    CC_TERM   = 3'd4,
    CC_OTHER  = 3'd5
  } nl_class_e;

  // aux[0]: a digit has been seen in the current segment (frac: mantissa,
  //         exp: exponent). aux[1]: exponent minus already consumed.
  typedef struct packed {
    nl_state_e              st;
    logic [AUX_W-1:0]       aux;
  } nl_ctx_t;

  localparam nl_ctx_t CTX_RESET = '{st: ST_START, aux: '0};

  function automatic nl_ctx_t nl_go(input nl_state_e s, input logic [AUX_W-1:0] a);
    nl_ctx_t r;
    r.st  = s;
    r.aux = a;
    return r;
  endfunction

  function automatic nl_ctx_t nl_step_fn(input nl_ctx_t c, input nl_class_e k);
    nl_ctx_t n;
    n = nl_go(ST_ERROR, 2'b00);
    case (c.st)
      ST_START: begin
        case (k)
          CC_DIGIT: n = nl_go(ST_WHOLE, 2'b00);
          CC_MINUS: n = nl_go(ST_SIGN, 2'b00);
          CC_DOT:   n = nl_go(ST_FRAC, 2'b00);
          default:  n = nl_go(ST_ERROR, 2'b00);
        endcase
      end
      ST_SIGN: begin
        case (k)
          CC_DIGIT: n = nl_go(ST_WHOLE, 2'b00);
          CC_DOT:   n = nl_go(ST_FRAC, 2'b00);
          default:  n = nl_go(ST_ERROR, 2'b00);
        endcase
      end
      ST_WHOLE: begin
        case (k)
          CC_DIGIT:  n = nl_go(ST_WHOLE, 2'b00);
          CC_DOT:    n = nl_go(ST_FRAC, 2'b01);
          CC_EXPMRK: n = nl_go(ST_EXP, 2'b00);
          CC_TERM:   n = nl_go(ST_DONE, 2'b00);
          default:   n = nl_go(ST_ERROR, 2'b00);
        endcase
      end
      ST_FRAC: begin
        case (k)
          CC_DIGIT:  n = nl_go(ST_FRAC, 2'b01);
          CC_EXPMRK: n = c.aux[0] ? nl_go(ST_EXP, 2'b00) : nl_go(ST_ERROR, 2'b00);
          CC_TERM:   n = c.aux[0] ? nl_go(ST_DONE, 2'b00) : nl_go(ST_ERROR, 2'b00);
          default:   n = nl_go(ST_ERROR, 2'b00);
        endcase
      end
      ST_EXP: begin
        case (k)
          CC_DIGIT: n = nl_go(ST_EXP, {c.aux[1], 1'b1});
          CC_MINUS: n = (c.aux == 2'b00) ? nl_go(ST_EXP, 2'b10) : nl_go(ST_ERROR, 2'b00);
          CC_TERM:  n = c.aux[0] ? nl_go(ST_DONE, 2'b00) : nl_go(ST_ERROR, 2'b00);
          default:  n = nl_go(ST_ERROR, 2'b00);
        endcase
      end
      ST_DONE:  n = nl_go(ST_DONE, 2'b00);
      default:  n = nl_go(ST_ERROR, 2'b00);
    endcase
    return n;
  endfunction

endpackage

// File: rtl/numlex_classify.sv
`timescale 1ns/1ps
module numlex_classify
  import numlex_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic [CHAR_W-1:0] char_i,
  output nl_class_e         cls_o
);

  localparam logic [CHAR_W-1:0] C_ZERO  = CHAR_W'(8'h30);
  localparam logic [CHAR_W-1:0] C_NINE  = CHAR_W'(8'h39);
  localparam logic [CHAR_W-1:0] C_MINUS = CHAR_W'(8'h2D);
  localparam logic [CHAR_W-1:0] C_DOT   = CHAR_W'(8'h2E);
  localparam logic [CHAR_W-1:0] C_EXP   = CHAR_W'(8'h65);
  localparam int                N_TERM  = 5;
  localparam logic [N_TERM*CHAR_W-1:0] TERM_SET = {
    CHAR_W'(8'h20), CHAR_W'(8'h09), CHAR_W'(8'h0D), CHAR_W'(8'h0A), CHAR_W'(8'h00)
  };

  logic [N_TERM-1:0] term_hit;

  generate
    for (genvar g = 0; g < N_TERM; g++) begin : g_term
      assign term_hit[g] = (char_i == TERM_SET[g*CHAR_W +: CHAR_W]);
    end
  endgenerate

  always_comb begin
    if (char_i >= C_ZERO && char_i <= C_NINE) cls_o = CC_DIGIT;
    else if (char_i == C_MINUS)               cls_o = CC_MINUS;
    else if (char_i == C_DOT)                 cls_o = CC_DOT;
    else if (char_i == C_EXP)                 cls_o = CC_EXPMRK;
    else if (|term_hit)                       cls_o = CC_TERM;
    else                                      cls_o = CC_OTHER;
  end

  always_comb begin
    assert ($onehot0(term_hit)) else $error("AST_TERM_UNIQUE"); // R6
  end

endmodule

// File: rtl/numlex_step.sv
`timescale 1ns/1ps
module numlex_step
  import numlex_pkg::*;
#(
  parameter bit USE_TABLE = 1'b0
) (
  input  nl_ctx_t   ctx_i,
  input  nl_class_e cls_i,
  output nl_ctx_t   ctx_o
);

  localparam int SLOTS = 1 << IDX_W;

  generate
    if (USE_TABLE) begin : g_table
      logic [CTX_W-1:0] rom [0:SLOTS-1];
      logic [IDX_W-1:0] idx;

      initial begin
        for (int i = 0; i < SLOTS; i++) begin
          logic [IDX_W-1:0] ii;
          ii = IDX_W'(i);
          rom[i] = nl_step_fn(nl_ctx_t'(ii[IDX_W-1:CLS_W]), nl_class_e'(ii[CLS_W-1:0]));
        end
      end

      assign idx   = {ctx_i, cls_i};
      assign ctx_o = nl_ctx_t'(rom[idx]);
    end else begin : g_logic
      always_comb ctx_o = nl_step_fn(ctx_i, cls_i);
    end
  endgenerate

endmodule

// File: rtl/numlex_track.sv
`timescale 1ns/1ps
module numlex_track
  import numlex_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    adv_i,
  input  nl_ctx_t ctx_n_i,
  output nl_ctx_t ctx_q_o,
  output logic    ok_o,
  output logic    err_o
);

  nl_ctx_t ctx_q;
  logic    ok_q, err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctx_q <= CTX_RESET;
      ok_q  <= 1'b0;
      err_q <= 1'b0;
    end else if (adv_i) begin
      ctx_q <= ctx_n_i;
      ok_q  <= (ctx_n_i.st == ST_DONE);
      err_q <= (ctx_n_i.st == ST_ERROR);
    end
  end

  assign ctx_q_o = ctx_q;
  assign ok_o    = ok_q;
  assign err_o   = err_q;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q); // R9
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    ok_q |=> ok_q); // R9
  AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ok_q && err_q)); // R10
  AST_OK_TRACKS_STATE: assert property (@(posedge clk) disable iff (rst)
    (ok_q == (ctx_q.st == ST_DONE)) && (err_q == (ctx_q.st == ST_ERROR))); // R10
  AST_NO_CODE7: assert property (@(posedge clk) disable iff (rst)
    ctx_q.st != 3'b111); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> $stable(ctx_q) && $stable(ok_q) && $stable(err_q)); // R2
  AST_RESET_START: assert property (@(posedge clk)
    $past(rst) |-> (ctx_q.st == ST_START) && !ok_q && !err_q); // R1

endmodule

// File: rtl/numlex_top.sv
`timescale 1ns/1ps
module numlex_top
  import numlex_pkg::*;
#(
  parameter int CHAR_W    = 8,
  parameter bit USE_TABLE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_char,
  output logic [ST_W-1:0]   state_o,
  output logic              num_ok,
  output logic              num_err
);

  nl_class_e cls;
  nl_ctx_t   ctx_q, ctx_n;

  numlex_classify #(.CHAR_W(CHAR_W)) u_cls (
    .char_i (in_char),
    .cls_o  (cls)
  );

  numlex_step #(.USE_TABLE(USE_TABLE)) u_step (
    .ctx_i (ctx_q),
    .cls_i (cls),
    .ctx_o (ctx_n)
  );

  numlex_track u_track (
    .clk     (clk),
    .rst     (rst),
    .adv_i   (in_valid),
    .ctx_n_i (ctx_n),
    .ctx_q_o (ctx_q),
    .ok_o    (num_ok),
    .err_o   (num_err)
  );

  assign state_o = ctx_q.st;

  AST_DONE_NEEDS_TERM: assert property (@(posedge clk) disable iff (rst)
    $rose(num_ok) |-> $past(in_valid && cls == CC_TERM)); // R6
  AST_SIGN_ONLY_FROM_START: assert property (@(posedge clk) disable iff (rst)
    $changed(state_o) && state_o == ST_SIGN |-> $past(state_o) == ST_START && $past(cls) == CC_MINUS); // R4
  AST_EXP_NEEDS_MARK: assert property (@(posedge clk) disable iff (rst)
    $changed(state_o) && state_o == ST_EXP |-> $past(cls) == CC_EXPMRK); // R5

endmodule

// File: tb/numlex_top_test.sv
`timescale 1ns/1ps
module numlex_top_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_char = 8'h00;
  logic [2:0] state_o;
  logic       num_ok, num_err;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  localparam logic [2:0] S_START = 3'b000, S_SIGN = 3'b001, S_WHOLE = 3'b010,
                         S_FRAC = 3'b011, S_EXP = 3'b100, S_DONE = 3'b101, S_ERR = 3'b110;

  always #4 clk = ~clk;

  numlex_top uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_char(in_char),
    .state_o(state_o), .num_ok(num_ok), .num_err(num_err)
  );

  task automatic check_state(input string req, input logic [2:0] exp_st);
    n_run++;
    if (state_o !== exp_st || num_ok !== (exp_st == S_DONE) || num_err !== (exp_st == S_ERR)) begin
      n_fail++;
      $display("FAIL %s: state=%b ok=%b err=%b expected state=%b ok=%b err=%b",
               req, state_o, num_ok, num_err, exp_st, exp_st == S_DONE, exp_st == S_ERR);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; in_valid = 1'b0;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); in_valid = 1'b1; in_char = b;
  endtask

  task automatic settle();
    @(negedge clk); in_valid = 1'b0; in_char = 8'h5A;
  endtask

  task automatic feed(input string s);
    for (int i = 0; i < s.len(); i++) send(s[i]);
  endtask

  task automatic run_case(input string req, input string s, input logic [7:0] term,
                          input bit use_term, input logic [2:0] exp_st);
    do_reset();
    feed(s);
    if (use_term) send(term);
    settle();
    check_state({req, " \"", s, "\""}, exp_st);
  endtask

  task automatic t_reset();
    do_reset();
    check_state("R1 after reset", S_START);
    feed("12");
    @(negedge clk); rst = 1'b1; in_valid = 1'b1; in_char = 8'h31;
    @(negedge clk); rst = 1'b0; in_valid = 1'b0;
    check_state("R1 reset beats valid char", S_START);
  endtask

  task automatic t_accept();
    run_case("R4 R5 R6", "123.456e23", 8'h20, 1'b1, S_DONE);
    run_case("R4 R6", ".456", 8'h0A, 1'b1, S_DONE);
    run_case("R5 R6", "1.5e-10", 8'h09, 1'b1, S_DONE);
    run_case("R4 R6", "-123", 8'h00, 1'b1, S_DONE);
    run_case("R4 R6", "5.", 8'h0D, 1'b1, S_DONE);
    run_case("R4 R5", "-.5e7", 8'h20, 1'b1, S_DONE);
  endtask

  task automatic t_walk();
    do_reset();
    send(8'h2D); settle(); check_state("R3 sign", S_SIGN);
    send(8'h37); settle(); check_state("R3 whole", S_WHOLE);
    send(8'h2E); settle(); check_state("R3 frac", S_FRAC);
    send(8'h32); settle(); check_state("R3 frac digit", S_FRAC);
    send(8'h65); settle(); check_state("R3 exp", S_EXP);
    send(8'h2D); settle(); check_state("R5 exp minus", S_EXP);
    send(8'h34); settle(); check_state("R5 exp digit", S_EXP);
    send(8'h20); settle(); check_state("R3 done", S_DONE);
  endtask

  task automatic t_reject();
    run_case("R8 lone minus", "-", 8'h20, 1'b1, S_ERR);
    run_case("R8 lone dot", ".", 8'h20, 1'b1, S_ERR);
    run_case("R8 bare e", "1e", 8'h20, 1'b1, S_ERR);
    run_case("R8 e minus", "1e-", 8'h0A, 1'b1, S_ERR);
    run_case("R5 double minus", "1e--", 8'h00, 1'b0, S_ERR);
    run_case("R5 late minus", "1e5-", 8'h00, 1'b0, S_ERR);
    run_case("R5 uppercase E", "1E5", 8'h00, 1'b0, S_ERR);
    run_case("R5 e without mantissa", ".e5", 8'h00, 1'b0, S_ERR);
    run_case("R7 second dot", "1.2.3", 8'h00, 1'b0, S_ERR);
    run_case("R7 letter", "12a", 8'h00, 1'b0, S_ERR);
    run_case("R7 leading space", " 1", 8'h00, 1'b0, S_ERR);
    run_case("R7 minus after digit", "1-", 8'h00, 1'b0, S_ERR);
  endtask

  task automatic t_sticky();
    do_reset();
    feed("x"); settle(); check_state("R7 other char", S_ERR);
    feed("123 "); settle(); check_state("R9 error stays", S_ERR);
    do_reset();
    feed("7 "); settle(); check_state("R9 done reached", S_DONE);
    feed("x8-"); settle(); check_state("R9 done stays", S_DONE);
    do_reset(); check_state("R1 recovery", S_START);
  endtask

  task automatic t_hold();
    do_reset();
    feed("4.");
    settle();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); in_valid = 1'b0; in_char = (i % 2 == 0) ? 8'h78 : 8'h20;
    end
    check_state("R2 idle garbage ignored", S_FRAC);
    feed("9e1 "); settle();
    check_state("R2 continues after idle", S_DONE);
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hang, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_accept();
    t_walk();
    t_reject();
    t_sticky();
    t_hold();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule